// File: doc/BRIEF.md
# SMBus Host Status Register Unit

This unit holds the 8-bit status register of an SMBus host controller. Event inputs from the bus engine set the status bits. Software reads the register through a simple port and clears a bit by writing a one to it. The unit also combines the status bits into a single interrupt request.

Four bits carry state. Bit 7 is byte-done. Bit 6 is a software ownership semaphore. Bit 5 is alert status. Bit 1 is the completion interrupt. Every other bit reads 0.

During a block message the completion interrupt is held back. The engine signals the final byte, and byte-done sets. The interrupt bit only rises when software clears byte-done. A block of n bytes therefore produces n+1 interrupt events.

The semaphore bit lets independent software threads take ownership of the host controller. A read returns the current value of the bit and then sets it. A later write of one releases the bit.

The register is presented continuously on `rd_data`. A pulse on `rd_en` marks a software read, which matters only for the semaphore.

There are two synchronous active-low resets:
- The general reset clears bits 7, 6 and 1.
- The resume-domain reset is the only reset that clears bit 5.

Top module: `smb_hsts_unit`

## Requirements
- R1: A write with a one at position 7, 6, 5 or 1 clears that bit when no set event hits it in the same cycle. A write with a zero at a position leaves that bit unchanged.
- R2: Byte-done (bit 7) sets on a byte event when buffer mode is off and the heartbeat flag is low. This includes the last byte of a block.
- R3: Byte-done does not set on a byte event that has the heartbeat flag high, or that arrives while buffer mode is on.
- R4: On a last-byte event byte-done sets, but the interrupt bit (bit 1) stays clear. Bit 1 sets at the clock edge where software clears byte-done. An n-byte block therefore shows n+1 rising edges of bit 7 and bit 1 combined.
- R5: A transaction-done event sets bit 1 on the next clock edge.
- R6: The semaphore (bit 6):
  - reads 0 after general reset;
  - a read returns its value from before the read;
  - it is 1 from the next clock on;
  - a write of one at bit 6 makes it 0;
  - a write of zero at bit 6 has no effect.
- R7: Alert status (bit 5) sets while the alert input is high and the alert pin is not configured as general-purpose I/O. It never sets while that configuration input is high.
- R8: Alert status is cleared only by a write of one at bit 5 or by the resume-domain reset. The general reset leaves it unchanged.
- R9: When a set event and a write-one clear hit the same bit in the same cycle, the bit ends up set.
- R10: The interrupt request is high exactly when the interrupt enable is high and any of bits 7, 5 or 1 is set.
- R11: The general reset clears bits 7, 6 and 1. Bits 4, 3, 2 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | General synchronous reset, active low |
| rsm_rst_n | input | 1 | Resume-domain synchronous reset, active low (alert bit only) |
| rd_en | input | 1 | Software read strobe for this register |
| wr_en | input | 1 | Software write strobe for this register |
| wr_data | input | 8 | Write data; a one clears the bit at that position |
| rd_data | output | 8 | Current register value |
| ev_byte | input | 1 | Engine moved one byte of a block transfer |
| ev_last | input | 1 | Qualifies ev_byte as the final byte of the block |
| ev_hbeat | input | 1 | Qualifies ev_byte as a heartbeat transfer |
| buf_mode | input | 1 | 32-byte buffer mode enabled |
| ev_done | input | 1 | Engine finished a transaction |
| alert_in | input | 1 | Alert pin asserted (active high here) |
| alert_gpio | input | 1 | Alert pin configured as general-purpose I/O |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the deferred completion. Bit 1 must stay low after a last-byte event. It must rise only at the edge where software clears byte-done. A single table row cannot show this.

The stimulus runs a three-byte block and acts as the handler: it clears byte-done after each byte. It counts rising edges of bits 7 and 1 and expects four.

A second hard case is the pair of reset domains. A directed test first fills all four bits. It then applies each reset alone, to show that bit 5 survives the general reset and falls only on the resume reset.

// File: rtl/smb_hsts_pkg.sv
// Package: register width and bit positions for the host status unit.
// Assumes one 8-bit register; positions are fixed because software decodes them.
package smb_hsts_pkg;
    localparam int REG_W   = 8;
    localparam int BIT_BD  = 7;   // byte done
    localparam int BIT_SEM = 6;   // ownership semaphore
    localparam int BIT_ALR = 5;   // alert status
    localparam int BIT_INT = 1;   // completion interrupt
endpackage

// File: rtl/hsts_sticky_bit.sv
// Module: one status bit, set by hardware, cleared by a write-one strobe.
// Assumes set has priority over clear so that no event is dropped.
module hsts_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Purpose: hold the bit; set wins over clear; synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= 1'b0;
        else if (set)    q <= 1'b1;
        else if (clr)    q <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q); // R9
    AST_HOLD_NO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clr) |=> q); // R1
endmodule

// File: rtl/hsts_semaphore.sv
// Module: ownership semaphore that sets itself on the clock after a read.
// Assumes the read value is taken combinationally before the edge.
module hsts_semaphore (
    input  logic clk,
    input  logic rst_n,
    input  logic rd,
    input  logic clr,
    output logic q
);
    // Purpose: a read sets the bit for the next cycle; a write-one releases it.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= 1'b0;
        else if (rd)     q <= 1'b1;
        else if (clr)    q <= 1'b0;
    end

    AST_SEMA_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd && !q) |=> !q); // R6
    AST_SEMA_READ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> q); // R6
endmodule

// File: rtl/hsts_defer.sv
// Module: remembers a pending block completion until byte done is cleared.
// Assumes last_set and bd_release never occur together (a release needs no set).
module hsts_defer (
    input  logic clk,
    input  logic rst_n,
    input  logic last_set,
    input  logic bd_release,
    output logic pend,
    output logic fire
);
    assign fire = pend & bd_release;

    // Purpose: track whether the final byte's completion is still owed.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend <= 1'b0;
        else if (last_set) pend <= 1'b1;
        else if (fire)     pend <= 1'b0;
    end

    AST_PEND_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !last_set) |=> !pend); // R4
endmodule

// File: rtl/smb_hsts_unit.sv
// Module: SMBus host status register with W1C bits, read-set semaphore,
// alert capture in the resume domain and deferred block completion.
// Assumes the engine does not raise ev_done for the final byte of a block.
module smb_hsts_unit
    import smb_hsts_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rsm_rst_n,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             ev_byte,
    input  logic             ev_last,
    input  logic             ev_hbeat,
    input  logic             buf_mode,
    input  logic             ev_done,
    input  logic             alert_in,
    input  logic             alert_gpio,
    input  logic             irq_en,
    output logic             irq
);
    logic bd_q, sem_q, alr_q, int_q;
    logic bd_set, bd_clr, bd_release, last_set;
    logic alr_set, int_set;
    logic pend, fire;
    logic [REG_W-1:0] clr_mask;

    // Purpose: decode write-one clear strobes per bit position.
    assign clr_mask = wr_en ? wr_data : '0;

    // Purpose: qualify byte events; buffer mode and heartbeat block byte done.
    assign bd_set     = ev_byte & ~buf_mode & ~ev_hbeat;
    assign last_set   = bd_set & ev_last;
    assign bd_clr     = clr_mask[BIT_BD];
    assign bd_release = bd_clr & bd_q & ~bd_set;

    // Purpose: alert capture is suppressed while the pin is a GPIO.
    assign alr_set = alert_in & ~alert_gpio;

    // Purpose: completion interrupt from a plain transaction or a released block.
    assign int_set = ev_done | fire;

    hsts_sticky_bit u_bd (
        .clk(clk), .rst_n(rst_n), .set(bd_set), .clr(bd_clr), .q(bd_q));

    hsts_sticky_bit u_alr (
        .clk(clk), .rst_n(rsm_rst_n), .set(alr_set),
        .clr(clr_mask[BIT_ALR]), .q(alr_q));

    hsts_sticky_bit u_int (
        .clk(clk), .rst_n(rst_n), .set(int_set),
        .clr(clr_mask[BIT_INT]), .q(int_q));

    hsts_semaphore u_sem (
        .clk(clk), .rst_n(rst_n), .rd(rd_en),
        .clr(clr_mask[BIT_SEM]), .q(sem_q));

    hsts_defer u_defer (
        .clk(clk), .rst_n(rst_n), .last_set(last_set),
        .bd_release(bd_release), .pend(pend), .fire(fire));

    // Purpose: assemble the register image; unused positions read zero.
    always_comb begin
        rd_data          = '0;
        rd_data[BIT_BD]  = bd_q;
        rd_data[BIT_SEM] = sem_q;
        rd_data[BIT_ALR] = alr_q;
        rd_data[BIT_INT] = int_q;
    end

    // Purpose: request an interrupt while any interrupting bit is set.
    assign irq = irq_en & (bd_q | alr_q | int_q);

    AST_NO_BD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!bd_q && (!ev_byte || buf_mode || ev_hbeat)) |=> !rd_data[BIT_BD]); // R3
    AST_ALERT_GPIO: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        (!alr_q && alert_gpio) |=> !rd_data[BIT_ALR]); // R7
    AST_INT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_q && last_set && !ev_done) |=> !rd_data[BIT_INT]); // R4
    AST_ALERT_KEEP_W0: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        (alr_q && !(wr_en && wr_data[BIT_ALR])) |=> rd_data[BIT_ALR]); // R8
endmodule

// File: tb/smb_hsts_unit_tb.sv
module smb_hsts_unit_tb;
    logic clk = 1'b0;
    logic rst_n, rsm_rst_n, rd_en, wr_en;
    logic [7:0] wr_data, rd_data;
    logic ev_byte, ev_last, ev_hbeat, buf_mode, ev_done;
    logic alert_in, alert_gpio, irq_en, irq;
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    smb_hsts_unit u_dut (
        .clk(clk), .rst_n(rst_n), .rsm_rst_n(rsm_rst_n), .rd_en(rd_en),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .ev_byte(ev_byte), .ev_last(ev_last), .ev_hbeat(ev_hbeat),
        .buf_mode(buf_mode), .ev_done(ev_done), .alert_in(alert_in),
        .alert_gpio(alert_gpio), .irq_en(irq_en), .irq(irq));

    // Row: [31] wr [30:23] wdata [22] rd [21] byte [20] last [19] hb [18] buf
    // [17] done [16] alert [15] gpio [14] irq_en [13:6] exp reg [5] exp irq [4:0] req
    function automatic logic [31:0] v(input logic wr, input logic [7:0] wd,
        input logic rd, input logic eb, input logic el, input logic hb,
        input logic bm, input logic dn, input logic al, input logic gp,
        input logic ie, input logic [7:0] es, input logic ei, input logic [4:0] rq);
        return {wr, wd, rd, eb, el, hb, bm, dn, al, gp, ie, es, ei, rq};
    endfunction

    localparam int NV = 23;
    localparam logic [31:0] VEC [NV] = '{
        v(0,8'h00,0,1,0,0,0,0,0,0,0,8'h80,0,5'd2),  // R2 byte sets bd
        v(1,8'h00,0,0,0,0,0,0,0,0,0,8'h80,0,5'd1),  // R1 write 0 keeps
        v(1,8'h80,0,0,0,0,0,0,0,0,0,8'h00,0,5'd1),  // R1 write 1 clears
        v(0,8'h00,0,1,0,1,0,0,0,0,0,8'h00,0,5'd3),  // R3 heartbeat
        v(0,8'h00,0,1,0,0,1,0,0,0,0,8'h00,0,5'd3),  // R3 buffer mode
        v(0,8'h00,0,1,1,0,0,0,0,0,1,8'h80,1,5'd4),  // R4 last byte, bit1 held
        v(0,8'h00,0,0,0,0,0,0,0,0,1,8'h80,1,5'd4),  // R4 still held
        v(1,8'h80,0,0,0,0,0,0,0,0,1,8'h02,1,5'd4),  // R4 release on clear
        v(1,8'h02,0,0,0,0,0,0,0,0,0,8'h00,0,5'd1),  // R1
        v(0,8'h00,0,0,0,0,0,1,0,0,0,8'h02,0,5'd5),  // R5 done, R10 en low
        v(0,8'h00,0,0,0,0,0,0,0,0,1,8'h02,1,5'd10), // R10
        v(1,8'h02,0,0,0,0,0,1,0,0,0,8'h02,0,5'd9),  // R9 set wins
        v(1,8'h02,0,0,0,0,0,0,0,0,0,8'h00,0,5'd1),  // R1
        v(0,8'h00,0,0,0,0,0,0,1,1,1,8'h00,0,5'd7),  // R7 gpio blocks
        v(0,8'h00,0,0,0,0,0,0,1,0,1,8'h20,1,5'd7),  // R7 alert sets
        v(1,8'h20,0,0,0,0,0,0,1,0,0,8'h20,0,5'd9),  // R9 alert set wins
        v(1,8'hDF,0,0,0,0,0,0,0,0,0,8'h20,0,5'd8),  // R8 other ones keep it
        v(1,8'h20,0,0,0,0,0,0,0,0,0,8'h00,0,5'd8),  // R8 write 1 clears
        v(0,8'h00,1,0,0,0,0,0,0,0,0,8'h40,0,5'd6),  // R6 read sets
        v(1,8'h00,0,0,0,0,0,0,0,0,1,8'h40,0,5'd6),  // R6 write 0 keeps
        v(1,8'h40,0,0,0,0,0,0,0,0,0,8'h00,0,5'd6),  // R6 write 1 releases
        v(1,8'h80,0,1,0,0,0,0,0,0,0,8'h80,0,5'd9),  // R9 bd set wins
        v(1,8'hFF,0,0,0,0,0,0,0,0,0,8'h00,0,5'd11)  // R11 unused bits zero
    };

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        rd_en = 0; wr_en = 0; wr_data = 0; ev_byte = 0; ev_last = 0;
        ev_hbeat = 0; buf_mode = 0; ev_done = 0; alert_in = 0;
        alert_gpio = 0; irq_en = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #2000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int cnt;
        logic [7:0] prev;
        idle();
        rst_n = 0; rsm_rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1; rsm_rst_n = 1;
        @(negedge clk);
        check8("R11 reset", rd_data, 8'h00);
        check8("R10 reset irq", {7'd0, irq}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] r;
            r = VEC[i];
            {wr_en, wr_data, rd_en, ev_byte, ev_last, ev_hbeat, buf_mode,
             ev_done, alert_in, alert_gpio, irq_en} = r[31:14];
            @(negedge clk);
            check8($sformatf("R%0d row %0d reg", r[4:0], i), rd_data, r[13:6]);
            check8($sformatf("R%0d row %0d irq", r[4:0], i), {7'd0, irq}, {7'd0, r[5]});
            idle();
        end

        // R6: a read returns the pre-read value, the set shows a cycle later
        rd_en = 1;
        #1 check8("R6 read sees old", rd_data, 8'h00);
        @(negedge clk);
        rd_en = 0;
        check8("R6 set after read", rd_data, 8'h40);

        // R8 / R11: fill bits, then general reset keeps only alert
        ev_byte = 1; ev_done = 1; alert_in = 1;
        @(negedge clk);
        idle();
        check8("R2 R5 R7 filled", rd_data, 8'hE2);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        check8("R8 R11 general reset", rd_data, 8'h20);
        rsm_rst_n = 0;
        @(negedge clk);
        rsm_rst_n = 1;
        check8("R8 resume reset", rd_data, 8'h00);

        // R4: three-byte block, handler clears bd each time: expect 4 events
        cnt = 0;
        prev = rd_data;
        for (int k = 0; k < 3; k++) begin
            ev_byte = 1; ev_last = (k == 2);
            @(negedge clk);
            idle();
            if (rd_data[7] && !prev[7]) cnt++;
            if (rd_data[1] && !prev[1]) cnt++;
            prev = rd_data;
            wr_en = 1; wr_data = 8'h80;
            @(negedge clk);
            idle();
            if (rd_data[7] && !prev[7]) cnt++;
            if (rd_data[1] && !prev[1]) cnt++;
            prev = rd_data;
        end
        check8("R4 n+1 events", cnt[7:0], 8'd4);
        check8("R4 final state", rd_data, 8'h02);
        wr_en = 1; wr_data = 8'h02;
        @(negedge clk);
        idle();
        check8("R1 final clear", rd_data, 8'h00);
        finish_run();
    end
endmodule